// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the configuration front end of a legacy I/O-port peripheral. A host reaches it through two byte ports on a simple I/O bus. The lower port selects a register number, and the port one address above it reads or writes the register that was selected. The configuration space starts out locked. It opens only after a fixed four-byte key has been written to the index port. Writing the exit value to the exit register locks it again.

When the space is open, it holds a few global registers and a logical-device selector. The global registers are the chip identifier, the revision and the selector itself. When the selector names the GPIO device, further registers become reachable: a 16-bit I/O base address, one output-enable byte per group of eight lines, and one simple-I/O enable byte for each of the first few groups. These registers drive a GPIO bank directly through output ports. Read data is combinational and is valid in the same cycle as the read strobe.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked, the device selector reads 0x00, and `gpio_base`, `gpio_oe` and `gpio_sio_en` are all zero.
- R2: The space opens only when 0x87, 0x01, 0x55 and 0x55 are written in that order to the index port (default address 0x2E). `cfg_open` rises in the cycle after the last byte.
- R3: While locked, an index-port byte that does not match the next key byte sends the matcher back to the start. A new complete key is then needed; for example, 87 01 00 55 55 and 87 87 01 55 55 both leave the port locked.
- R4: While locked, every read of the data port returns 0xFF. Data-port writes and index-port writes change no register.
- R5: While open, writing 0x02 to register 0x02 locks the port. Any other value written to 0x02 leaves it open.
- R6: Register 0x07 is the logical-device selector, and it can be both read and written.
- R7: Registers 0x20 and 0x21 return the high and low bytes of the chip identifier (default 0x8728). Register 0x22 returns the revision in its low nibble, with the upper nibble zero (default 0x01). Writes to these three registers are ignored.
- R8: When the selector equals the GPIO device number (0x07), register 0x62 holds bits 15:8 of `gpio_base` and register 0x63 holds bits 7:0.
- R9: When the GPIO device is selected, register 0xC8+g holds output-enable group g. Bit b of that register drives `gpio_oe[8g+b]`, for every g below the group count.
- R10: When the GPIO device is selected, register 0xC0+g holds simple-I/O group g for g below the simple-group count, and bit b drives `gpio_sio_en[8g+b]`. Indices from the simple-group count up to 0xC7 read as 0x00 and ignore writes.
- R11: When the selector holds any value other than the GPIO device number, the GPIO registers read as 0x00 and writes to them are ignored.
- R12: While open, a read of the index port returns the current index. Reads of any address other than the two ports return 0x00, and writes to such addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Byte write strobe |
| io_rd | input | 1 | Byte read strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational, 0x00 when no read is active |
| cfg_open | output | 1 | Configuration space is unlocked |
| gpio_base | output | 16 | GPIO I/O base address |
| gpio_oe | output | N_GROUPS*8 | Per-line output enables |
| gpio_sio_en | output | N_SIMPLE*8 | Per-line simple-I/O enables |

## Verification
The bench builds the block with its default parameters: index port 0x2E, identifier 0x8728, revision 1, eight output-enable groups and five simple-I/O groups. With eight groups, the last output-enable register sits at 0xCF, so the top byte of `gpio_oe` can be reached. With five simple groups, the unimplemented indices 0xC5 to 0xC7 lie between the two register arrays, and the bench writes to and reads from that gap. GPIO device number 0x07 is tested against a foreign selector value (0x03). This shows that the same index is gated by the selected device.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef enum logic [2:0] {
    KS_IDLE = 3'd0,
    KS_GOT1 = 3'd1,
    KS_GOT2 = 3'd2,
    KS_GOT3 = 3'd3,
    KS_OPEN = 3'd4
  } key_state_e;

  // unlock key, consumed in this order
  localparam logic [7:0] KEY_B0 = 8'h87;
  localparam logic [7:0] KEY_B1 = 8'h01;
  localparam logic [7:0] KEY_B2 = 8'h55;
  localparam logic [7:0] KEY_B3 = 8'h55;

  // register indices
  localparam logic [7:0] IDX_EXIT    = 8'h02;
  localparam logic [7:0] EXIT_VAL    = 8'h02;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_ID_HI   = 8'h20;
  localparam logic [7:0] IDX_ID_LO   = 8'h21;
  localparam logic [7:0] IDX_REV     = 8'h22;
  localparam logic [7:0] IDX_BASE_HI = 8'h62;
  localparam logic [7:0] IDX_BASE_LO = 8'h63;
  localparam logic [7:0] IDX_SIO0    = 8'hC0;
  localparam logic [7:0] IDX_OE0     = 8'hC8;

endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  input  logic       relock,
  output logic       unlocked
);

  key_state_e st_q, st_d;

  // next state: a mismatch always falls back to idle
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      KS_IDLE: if (key_wr) st_d = (key_byte == KEY_B0) ? KS_GOT1 : KS_IDLE;
      KS_GOT1: if (key_wr) st_d = (key_byte == KEY_B1) ? KS_GOT2 : KS_IDLE;
      KS_GOT2: if (key_wr) st_d = (key_byte == KEY_B2) ? KS_GOT3 : KS_IDLE;
      KS_GOT3: if (key_wr) st_d = (key_byte == KEY_B3) ? KS_OPEN : KS_IDLE;
      KS_OPEN: if (relock) st_d = KS_IDLE;
      default: st_d = KS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end

  assign unlocked = (st_q == KS_OPEN);

endmodule

// File: rtl/sio_gpio_bank.sv
module sio_gpio_bank
  import sio_pkg::*;
#(
  parameter int N_GROUPS = 8,
  parameter int N_SIMPLE = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel,
  input  logic                  wr,
  input  logic [7:0]            idx,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  output logic [15:0]           base,
  output logic [N_GROUPS*8-1:0] oe,
  output logic [N_SIMPLE*8-1:0] sio_en
);

  logic       we;
  logic [7:0] base_hi_q, base_lo_q;

  assign we = sel && wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          base_hi_q <= 8'h00;
    else if (we && idx == IDX_BASE_HI)   base_hi_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          base_lo_q <= 8'h00;
    else if (we && idx == IDX_BASE_LO)   base_lo_q <= wdata;
  end

  assign base = {base_hi_q, base_lo_q};

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_oe
    localparam logic [7:0] MY_IDX = IDX_OE0 + 8'(g);
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 q <= 8'h00;
      else if (we && idx == MY_IDX) q <= wdata;
    end
    assign oe[g*8 +: 8] = q;
  end

  for (genvar g = 0; g < N_SIMPLE; g++) begin : g_sio
    localparam logic [7:0] MY_IDX = IDX_SIO0 + 8'(g);
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 q <= 8'h00;
      else if (we && idx == MY_IDX) q <= wdata;
    end
    assign sio_en[g*8 +: 8] = q;
  end

  // read side: unmatched indices and a foreign device read as zero
  always_comb begin
    rdata = 8'h00;
    if (sel) begin
      if (idx == IDX_BASE_HI) rdata = base_hi_q;
      if (idx == IDX_BASE_LO) rdata = base_lo_q;
      for (int g = 0; g < N_GROUPS; g++)
        if (idx == IDX_OE0 + 8'(g)) rdata = oe[g*8 +: 8];
      for (int g = 0; g < N_SIMPLE; g++)
        if (idx == IDX_SIO0 + 8'(g)) rdata = sio_en[g*8 +: 8];
    end
  end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_pkg::*;
#(
  parameter logic [15:0] IDX_ADDR = 16'h002E,
  parameter logic [15:0] CHIP_ID  = 16'h8728,
  parameter logic [3:0]  CHIP_REV = 4'h1,
  parameter logic [7:0]  GPIO_LDN = 8'h07,
  parameter int          N_GROUPS = 8,
  parameter int          N_SIMPLE = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [15:0]           io_addr,
  input  logic [7:0]            io_wdata,
  output logic [7:0]            io_rdata,
  output logic                  cfg_open,
  output logic [15:0]           gpio_base,
  output logic [N_GROUPS*8-1:0] gpio_oe,
  output logic [N_SIMPLE*8-1:0] gpio_sio_en
);

  localparam logic [15:0] DATA_ADDR = IDX_ADDR + 16'd1;

  logic       hit_idx, hit_dat;
  logic       key_wr, idx_we, dat_we, relock, ldn_we, gpio_sel;
  logic [7:0] idx_q, idx_d, ldn_q, ldn_d, gpio_rdata;

  assign hit_idx = (io_addr == IDX_ADDR);
  assign hit_dat = (io_addr == DATA_ADDR);
  assign key_wr  = io_wr && hit_idx && !cfg_open;
  assign idx_we  = io_wr && hit_idx &&  cfg_open;
  assign dat_we  = io_wr && hit_dat &&  cfg_open;
  assign relock  = dat_we && (idx_q == IDX_EXIT) && (io_wdata == EXIT_VAL);
  assign ldn_we  = dat_we && (idx_q == IDX_LDN);
  assign gpio_sel = (ldn_q == GPIO_LDN);

  sio_key_fsm u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_byte (io_wdata),
    .relock   (relock),
    .unlocked (cfg_open)
  );

  // index and device selector: next-state then register
  always_comb begin
    idx_d = idx_we ? io_wdata : idx_q;
    ldn_d = ldn_we ? io_wdata : ldn_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= 8'h00;
      ldn_q <= 8'h00;
    end else begin
      idx_q <= idx_d;
      ldn_q <= ldn_d;
    end
  end

  sio_gpio_bank #(
    .N_GROUPS (N_GROUPS),
    .N_SIMPLE (N_SIMPLE)
  ) u_gpio (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (gpio_sel),
    .wr     (dat_we),
    .idx    (idx_q),
    .wdata  (io_wdata),
    .rdata  (gpio_rdata),
    .base   (gpio_base),
    .oe     (gpio_oe),
    .sio_en (gpio_sio_en)
  );

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd) begin
      if (hit_idx) begin
        io_rdata = cfg_open ? idx_q : 8'hFF;
      end else if (hit_dat) begin
        if (!cfg_open) io_rdata = 8'hFF;
        else begin
          unique case (idx_q)
            IDX_LDN:   io_rdata = ldn_q;
            IDX_ID_HI: io_rdata = CHIP_ID[15:8];
            IDX_ID_LO: io_rdata = CHIP_ID[7:0];
            IDX_REV:   io_rdata = {4'h0, CHIP_REV};
            default:   io_rdata = gpio_rdata;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter logic [15:0] IDX_ADDR = 16'h002E,
  parameter logic [15:0] CHIP_ID  = 16'h8728,
  parameter logic [7:0]  GPIO_LDN = 8'h07,
  parameter int          N_GROUPS = 8,
  parameter int          N_SIMPLE = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  io_wr,
  input logic                  io_rd,
  input logic [15:0]           io_addr,
  input logic [7:0]            io_wdata,
  input logic [7:0]            io_rdata,
  input logic                  cfg_open,
  input logic [15:0]           gpio_base,
  input logic [N_GROUPS*8-1:0] gpio_oe,
  input logic [N_SIMPLE*8-1:0] gpio_sio_en,
  input logic [7:0]            idx_q,
  input logic [7:0]            ldn_q
);

  localparam logic [15:0] DATA_ADDR = IDX_ADDR + 16'd1;

  // R2
  unlock_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(io_wr && io_addr == IDX_ADDR && io_wdata == 8'h55));

  // R3
  wrong_key_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && io_wr && io_addr == IDX_ADDR && io_wdata != 8'h87 &&
     io_wdata != 8'h01 && io_wdata != 8'h55) |=> !cfg_open);

  // R4
  locked_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && io_rd && io_addr == DATA_ADDR) |-> io_rdata == 8'hFF);

  // R4
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && io_wr && io_addr == DATA_ADDR) |=>
      ($stable(gpio_oe) && $stable(gpio_base) && $stable(gpio_sio_en)));

  // R5
  exit_relocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_wr && io_addr == DATA_ADDR && idx_q == 8'h02 && io_wdata == 8'h02)
      |=> !cfg_open);

  // R7
  chip_id_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_rd && io_addr == DATA_ADDR && idx_q == 8'h20)
      |-> io_rdata == CHIP_ID[15:8]);

  // R11
  foreign_ldn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ldn_q != GPIO_LDN) |=>
      ($stable(gpio_oe) && $stable(gpio_sio_en) && $stable(gpio_base)));

endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .IDX_ADDR (IDX_ADDR),
  .CHIP_ID  (CHIP_ID),
  .GPIO_LDN (GPIO_LDN),
  .N_GROUPS (N_GROUPS),
  .N_SIMPLE (N_SIMPLE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .io_wr       (io_wr),
  .io_rd       (io_rd),
  .io_addr     (io_addr),
  .io_wdata    (io_wdata),
  .io_rdata    (io_rdata),
  .cfg_open    (cfg_open),
  .gpio_base   (gpio_base),
  .gpio_oe     (gpio_oe),
  .gpio_sio_en (gpio_sio_en),
  .idx_q       (idx_q),
  .ldn_q       (ldn_q)
);

// File: tb/sim_sio_cfg_port.sv
module sim_sio_cfg_port;

  localparam logic [15:0] IA = 16'h002E;
  localparam logic [15:0] DA = 16'h002F;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_OPEN = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 50;
  localparam vec_t TBL [NV] = '{
    // R2 unlock
    '{OP_WR, IA, 8'h87, 8'd2}, '{OP_WR, IA, 8'h01, 8'd2}, '{OP_WR, IA, 8'h55, 8'd2},
    '{OP_WR, IA, 8'h55, 8'd2}, '{OP_OPEN, IA, 8'h01, 8'd2},
    // R7 identification, write ignored
    '{OP_WR, IA, 8'h20, 8'd7}, '{OP_RD, DA, 8'h87, 8'd7}, '{OP_WR, IA, 8'h21, 8'd7},
    '{OP_RD, DA, 8'h28, 8'd7}, '{OP_WR, IA, 8'h22, 8'd7}, '{OP_RD, DA, 8'h01, 8'd7},
    '{OP_WR, DA, 8'h55, 8'd7}, '{OP_RD, DA, 8'h01, 8'd7},
    // R12 index readback
    '{OP_RD, IA, 8'h22, 8'd12},
    // R1 selector reset value, R11 GPIO hidden while selector is 0
    '{OP_WR, IA, 8'h07, 8'd1}, '{OP_RD, DA, 8'h00, 8'd1}, '{OP_WR, IA, 8'hC8, 8'd11},
    '{OP_WR, DA, 8'hFF, 8'd11}, '{OP_RD, DA, 8'h00, 8'd11},
    // R6 selector
    '{OP_WR, IA, 8'h07, 8'd6}, '{OP_WR, DA, 8'h07, 8'd6}, '{OP_RD, DA, 8'h07, 8'd6},
    // R8 base address
    '{OP_WR, IA, 8'h62, 8'd8}, '{OP_WR, DA, 8'h12, 8'd8}, '{OP_WR, IA, 8'h63, 8'd8},
    '{OP_WR, DA, 8'h34, 8'd8}, '{OP_RD, DA, 8'h34, 8'd8}, '{OP_WR, IA, 8'h62, 8'd8},
    '{OP_RD, DA, 8'h12, 8'd8},
    // R9 output enables, first and last group
    '{OP_WR, IA, 8'hC8, 8'd9}, '{OP_WR, DA, 8'hA5, 8'd9}, '{OP_RD, DA, 8'hA5, 8'd9},
    '{OP_WR, IA, 8'hCF, 8'd9}, '{OP_WR, DA, 8'h3C, 8'd9}, '{OP_RD, DA, 8'h3C, 8'd9},
    // R10 last simple group and the gap above it
    '{OP_WR, IA, 8'hC4, 8'd10}, '{OP_WR, DA, 8'h5A, 8'd10}, '{OP_RD, DA, 8'h5A, 8'd10},
    '{OP_WR, IA, 8'hC5, 8'd10}, '{OP_WR, DA, 8'h77, 8'd10}, '{OP_RD, DA, 8'h00, 8'd10},
    // R12 foreign address
    '{OP_WR, 16'h0030, 8'hFF, 8'd12}, '{OP_RD, 16'h0030, 8'h00, 8'd12},
    '{OP_RD, IA, 8'hC5, 8'd12},
    // R5 exit register
    '{OP_WR, IA, 8'h02, 8'd5}, '{OP_WR, DA, 8'h01, 8'd5}, '{OP_OPEN, IA, 8'h01, 8'd5},
    '{OP_WR, DA, 8'h02, 8'd5}, '{OP_OPEN, IA, 8'h00, 8'd5}, '{OP_RD, DA, 8'hFF, 8'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_wr, io_rd;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata, io_rdata;
  logic        cfg_open;
  logic [15:0] gpio_base;
  logic [63:0] gpio_oe;
  logic [39:0] gpio_sio_en;

  int checks = 0;
  int fails  = 0;

  always #5ns clk = ~clk;

  sio_cfg_port u0 (
    .clk (clk), .rst_n (rst_n), .io_wr (io_wr), .io_rd (io_rd),
    .io_addr (io_addr), .io_wdata (io_wdata), .io_rdata (io_rdata),
    .cfg_open (cfg_open), .gpio_base (gpio_base), .gpio_oe (gpio_oe),
    .gpio_sio_en (gpio_sio_en)
  );

  task automatic check(input int req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [7:0] exp, input int req);
    @(negedge clk);
    io_rd = 1'b1; io_addr = a;
    #1ns;
    check(req, 64'(io_rdata), 64'(exp));
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic key(input logic [7:0] a, b, c, d);
    wr(IA, a); wr(IA, b); wr(IA, c); wr(IA, d);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #2ms;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; io_wr = 1'b0; io_rd = 1'b0; io_addr = '0; io_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        OP_WR: wr(TBL[i].addr, TBL[i].data);
        OP_RD: rd_chk(TBL[i].addr, TBL[i].data, int'(TBL[i].req));
        default: begin
          @(negedge clk);
          check(int'(TBL[i].req), 64'(cfg_open), 64'(TBL[i].data[0]));
        end
      endcase
    end

    // R8 R9 R10: register contents reach the ports with the stated bit mapping
    @(negedge clk);
    check(8, 64'(gpio_base), 64'h1234);
    check(9, 64'(gpio_oe[7:0]), 64'hA5);
    check(9, 64'(gpio_oe[0]), 64'h1);
    check(9, 64'(gpio_oe[1]), 64'h0);
    check(9, 64'(gpio_oe[63:56]), 64'h3C);
    check(10, 64'(gpio_sio_en[39:32]), 64'h5A);
    check(10, 64'(gpio_sio_en[31:0]), 64'h0);

    // R4: writes while locked go nowhere
    wr(IA, 8'hC8); wr(DA, 8'hFF);
    rd_chk(DA, 8'hFF, 4);
    check(4, 64'(gpio_oe[7:0]), 64'hA5);
    key(8'h87, 8'h01, 8'h55, 8'h55);
    @(negedge clk);
    check(4, 64'(cfg_open), 64'h1);
    rd_chk(IA, 8'h02, 4);
    rd_chk(DA, 8'h00, 4);

    // R11: foreign selector hides GPIO registers
    wr(IA, 8'h07); wr(DA, 8'h03);
    wr(IA, 8'hC8);
    rd_chk(DA, 8'h00, 11);
    wr(DA, 8'h11);
    check(11, 64'(gpio_oe[7:0]), 64'hA5);
    wr(IA, 8'h07); wr(DA, 8'h07); wr(IA, 8'hC8);
    rd_chk(DA, 8'hA5, 11);

    // R3: broken key sequences
    wr(IA, 8'h02); wr(DA, 8'h02);
    key(8'h87, 8'h01, 8'h00, 8'h55); wr(IA, 8'h55);
    @(negedge clk);
    check(3, 64'(cfg_open), 64'h0);
    wr(IA, 8'h87); key(8'h87, 8'h01, 8'h55, 8'h55);
    @(negedge clk);
    check(3, 64'(cfg_open), 64'h0);
    key(8'h87, 8'h01, 8'h55, 8'h55);
    @(negedge clk);
    check(3, 64'(cfg_open), 64'h1);

    // R1: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check(1, 64'(cfg_open), 64'h0);
    check(1, 64'(gpio_base), 64'h0);
    check(1, gpio_oe, 64'h0);
    check(1, 64'(gpio_sio_en), 64'h0);
    rd_chk(DA, 8'hFF, 1);
    key(8'h87, 8'h01, 8'h55, 8'h55);
    wr(IA, 8'h07);
    rd_chk(DA, 8'h00, 1);

    finish_run();
  end

endmodule